// File: doc/BRIEF.md
# Stream Port Get/Put Execution Unit

This execution unit moves 32-bit words between processor registers and a bank of FIFO-style stream ports. Each port has an outgoing side (data, a control flag and a full indication) and an incoming side (data, a control flag, an "exists" indication and a read strobe). The pipeline hands over a decoded stream instruction: its major opcode, a direction bit, an 11-bit flag field, the value of the register that names the port, and the value to send.

A get pops the selected incoming port and writes its word back to the destination register. A put pushes a word to the selected outgoing port. Flag bits pick blocking or polling behaviour, a control or data transfer, and a probe-only mode. The unit reports the outcome through a registered write-back stage. This stage carries the destination write, a carry update that polling accesses use to report status, and a stream-error set when the control flag of a popped word does not match the requested transfer type.

The pipeline keeps the instruction presented while `stall_o` is high. It drops `op_valid_i` after the cycle in which the access completes.

Top module: `sport_xfer`

## Requirements
- R1: An access is recognised only when `op_valid_i` is high, `opcode_i` equals 6'b010011, and the reserved flag bits `func_i[10]` and `func_i[4:0]` are zero. Any other input raises no stall, no strobe and no write-back.
- R2: A blocking access (`func_i[9]`=0) holds `stall_o` high, with no strobe, while the selected port cannot serve it. For a get this means exists is low. For a put this means full is high.
- R3: A get that completes with data present and probe mode off raises the selected port's read strobe for that one cycle. In the next cycle `rd_we_o` is 1 and `rd_data_o` carries the popped word.
- R4: A put (`is_put_i`=1) that completes with the port not full and probe mode off raises the selected port's write strobe for that one cycle. It presents `ra_i` on that port's data and drives its control flag to `func_i[8]`: 1 for a control put, 0 for a data put.
- R5: A polling get (`func_i[9]`=1) never stalls. In the next cycle it sets `carry_we_o`=1, with `carry_o` equal to the inverse of the port's exists. If the port is empty, it raises no read strobe and no `rd_we_o`.
- R6: A polling put never stalls. In the next cycle it sets `carry_we_o`=1, with `carry_o` equal to the port's full. If the port is full, it raises no write strobe.
- R7: A get that completes with data present raises `err_set_o` in the next cycle when the port's incoming control flag differs from `func_i[8]`. A data get therefore flags an incoming control flag of 1, and a control get flags an incoming control flag of 0.
- R8: With probe mode set (`func_i[7]`=1), stall, carry and error are evaluated as usual. No read or write strobe is raised, and `rd_we_o` stays 0.
- R9: The port index is taken from the low 4 bits of `rb_i`. All higher bits of `rb_i` are ignored.
- R10: While `rst_ni` is low, the write-back outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Instruction presented to the unit |
| opcode_i | input | 6 | Major opcode field |
| is_put_i | input | 1 | Direction: 1 put, 0 get |
| func_i | input | 11 | Flag field: [9] polling, [8] control, [7] probe, [6] atomic, [5] error enable |
| rb_i | input | 32 | Port index register value |
| ra_i | input | 32 | Value to send on a put |
| s_data_i | input | 512 | Incoming data, 32 bits per port |
| s_ctrl_i | input | 16 | Incoming control flag per port |
| s_exists_i | input | 16 | Incoming data available per port |
| s_read_o | output | 16 | Incoming pop strobe per port |
| m_data_o | output | 512 | Outgoing data, 32 bits per port |
| m_ctrl_o | output | 16 | Outgoing control flag per port |
| m_full_i | input | 16 | Outgoing port full per port |
| m_write_o | output | 16 | Outgoing push strobe per port |
| stall_o | output | 1 | Pipeline hold request |
| rd_we_o | output | 1 | Destination register write |
| rd_data_o | output | 32 | Destination register data |
| carry_we_o | output | 1 | Carry flag update |
| carry_o | output | 1 | New carry value |
| err_set_o | output | 1 | Stream-error status set |

## Verification
The assertions check on every cycle that at most one read strobe and one write strobe are active, and that a stall or probe access raises no strobe. They also check that a polling access never stalls, that foreign opcodes stay quiet, and that every pop is followed by a destination write. Data values, carry polarity for gets versus puts, control-flag mismatch detection and port selection from the masked index depend on the stimulus. Only the bench's scenarios show these, with the scoreboard comparing each write-back against values derived from the port state it set up.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam logic [5:0] OPC_STREAM = 6'b010011;

  typedef struct packed {
    logic hit;
    logic put;
    logic nb;
    logic ctl;
    logic test;
  } sp_op_t;
endpackage

// File: rtl/sport_decode.sv
module sport_decode
  import sport_pkg::*;
(
  input  logic        op_valid_i,
  input  logic [5:0]  opcode_i,
  input  logic        is_put_i,
  input  logic [10:0] func_i,
  output sp_op_t      op_o
);
  logic unused_flags;
  assign unused_flags = ^func_i[6:5];

  always_comb begin
    op_o.hit  = op_valid_i && (opcode_i == OPC_STREAM) &&
                !func_i[10] && (func_i[4:0] == 5'd0);
    op_o.put  = is_put_i;
    op_o.nb   = func_i[9];
    op_o.ctl  = func_i[8];
    op_o.test = func_i[7];
  end
endmodule

// File: rtl/sport_portsel.sv
module sport_portsel #(
  parameter int NPORT = 16,
  parameter int DW    = 32,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic [PW-1:0]       sel_i,
  input  logic [NPORT*DW-1:0] s_data_i,
  input  logic [NPORT-1:0]    s_ctrl_i,
  input  logic [NPORT-1:0]    s_exists_i,
  input  logic [NPORT-1:0]    m_full_i,
  input  logic                pop_i,
  input  logic                push_i,
  output logic [DW-1:0]       data_o,
  output logic                ctrl_o,
  output logic                exists_o,
  output logic                full_o,
  output logic [NPORT-1:0]    s_read_o,
  output logic [NPORT-1:0]    m_write_o
);
  logic [NPORT-1:0] hot;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign hot[i]       = (sel_i == PW'(i));
    assign s_read_o[i]  = pop_i  & hot[i];
    assign m_write_o[i] = push_i & hot[i];
  end

  always_comb begin
    data_o   = '0;
    ctrl_o   = 1'b0;
    exists_o = 1'b0;
    full_o   = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (hot[i]) begin
        data_o   = s_data_i[i*DW +: DW];
        ctrl_o   = s_ctrl_i[i];
        exists_o = s_exists_i[i];
        full_o   = m_full_i[i];
      end
    end
  end
endmodule

// File: rtl/sport_wb.sv
module sport_wb #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic [DW-1:0] data_i,
  input  logic          carry_we_i,
  input  logic          carry_i,
  input  logic          err_i,
  output logic          rd_we_o,
  output logic [DW-1:0] rd_data_o,
  output logic          carry_we_o,
  output logic          carry_o,
  output logic          err_set_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_we_o    <= 1'b0;
      rd_data_o  <= '0;
      carry_we_o <= 1'b0;
      carry_o    <= 1'b0;
      err_set_o  <= 1'b0;
    end else begin
      rd_we_o    <= pop_i;
      carry_we_o <= carry_we_i;
      carry_o    <= carry_i;
      err_set_o  <= err_i;
      if (pop_i) rd_data_o <= data_i;
    end
  end
endmodule

// File: rtl/sport_xfer.sv
module sport_xfer
  import sport_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int DW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [5:0]          opcode_i,
  input  logic                is_put_i,
  input  logic [10:0]         func_i,
  input  logic [DW-1:0]       rb_i,
  input  logic [DW-1:0]       ra_i,
  input  logic [NPORT*DW-1:0] s_data_i,
  input  logic [NPORT-1:0]    s_ctrl_i,
  input  logic [NPORT-1:0]    s_exists_i,
  output logic [NPORT-1:0]    s_read_o,
  output logic [NPORT*DW-1:0] m_data_o,
  output logic [NPORT-1:0]    m_ctrl_o,
  input  logic [NPORT-1:0]    m_full_i,
  output logic [NPORT-1:0]    m_write_o,
  output logic                stall_o,
  output logic                rd_we_o,
  output logic [DW-1:0]       rd_data_o,
  output logic                carry_we_o,
  output logic                carry_o,
  output logic                err_set_o
);
  localparam int PW = $clog2(NPORT);

  sp_op_t          op;
  logic [DW-1:0]   sel_data;
  logic            sel_ctrl, sel_exists, sel_full;
  logic            is_get, is_put, avail, done, pop, push;
  logic            carry_we, carry_nx, err_nx;
  logic            unused_rb;

  assign unused_rb = ^rb_i[DW-1:PW];

  sport_decode u_dec (
    .op_valid_i (op_valid_i),
    .opcode_i   (opcode_i),
    .is_put_i   (is_put_i),
    .func_i     (func_i),
    .op_o       (op)
  );

  assign is_get = op.hit & ~op.put;
  assign is_put = op.hit &  op.put;
  // port can serve the access now
  assign avail  = is_get ? sel_exists : ~sel_full;
  assign done   = op.hit & (op.nb | avail);
  assign stall_o = op.hit & ~op.nb & ~avail;
  assign pop    = is_get & avail & ~op.test;
  assign push   = is_put & avail & ~op.test;

  assign carry_we = done & op.nb;
  assign carry_nx = is_get ? ~sel_exists : sel_full;
  assign err_nx   = is_get & avail & (sel_ctrl != op.ctl);

  sport_portsel #(.NPORT(NPORT), .DW(DW), .PW(PW)) u_sel (
    .sel_i      (rb_i[PW-1:0]),
    .s_data_i   (s_data_i),
    .s_ctrl_i   (s_ctrl_i),
    .s_exists_i (s_exists_i),
    .m_full_i   (m_full_i),
    .pop_i      (pop),
    .push_i     (push),
    .data_o     (sel_data),
    .ctrl_o     (sel_ctrl),
    .exists_o   (sel_exists),
    .full_o     (sel_full),
    .s_read_o   (s_read_o),
    .m_write_o  (m_write_o)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_mout
    assign m_data_o[i*DW +: DW] = ra_i;
    assign m_ctrl_o[i]          = op.ctl;
  end

  sport_wb #(.DW(DW)) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (pop),
    .data_i     (sel_data),
    .carry_we_i (carry_we),
    .carry_i    (carry_nx),
    .err_i      (err_nx),
    .rd_we_o    (rd_we_o),
    .rd_data_o  (rd_data_o),
    .carry_we_o (carry_we_o),
    .carry_o    (carry_o),
    .err_set_o  (err_set_o)
  );

  p_one_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_read_o));
  p_one_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_write_o));
  p_stall_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (s_read_o == '0 && m_write_o == '0));
  p_pop_then_wb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|s_read_o) |=> rd_we_o);
  p_poll_no_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && func_i[9]) |-> !stall_o);
  p_probe_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && func_i[7]) |-> (s_read_o == '0 && m_write_o == '0));
  p_foreign_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i != OPC_STREAM) |-> (!stall_o && s_read_o == '0 && m_write_o == '0));
  p_foreign_no_wb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i) |=> (!rd_we_o && !carry_we_o && !err_set_o));
endmodule

// File: tb/sport_xfer_tb.sv
module sport_xfer_tb;
  localparam int CLK_P = 10;
  localparam int NP = 16;
  localparam int DW = 32;

  typedef struct packed {
    logic          rd_we;
    logic [DW-1:0] d;
    logic          cwe;
    logic          c;
    logic          err;
  } wb_t;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, is_put = 0;
  logic [5:0] opcode = 0;
  logic [10:0] func = 0;
  logic [DW-1:0] rb = 0, ra = 0;
  logic [NP*DW-1:0] s_data = 0;
  logic [NP-1:0] s_ctrl = 0, s_exists = 0, m_full = 0;
  logic [NP-1:0] s_read, m_ctrl, m_write;
  logic [NP*DW-1:0] m_data;
  logic stall, rd_we, carry_we, carry, err_set;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  bit finished = 0;
  wb_t exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  sport_xfer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .opcode_i(opcode),
    .is_put_i(is_put), .func_i(func), .rb_i(rb), .ra_i(ra),
    .s_data_i(s_data), .s_ctrl_i(s_ctrl), .s_exists_i(s_exists), .s_read_o(s_read),
    .m_data_o(m_data), .m_ctrl_o(m_ctrl), .m_full_i(m_full), .m_write_o(m_write),
    .stall_o(stall), .rd_we_o(rd_we), .rd_data_o(rd_data),
    .carry_we_o(carry_we), .carry_o(carry), .err_set_o(err_set)
  );

  function automatic logic [10:0] fn(logic n, logic c, logic t);
    return {1'b0, n, c, t, 2'b00, 5'b00000};
  endfunction

  function automatic wb_t mk(logic w, logic [DW-1:0] d, logic cw, logic c, logic e);
    wb_t r;
    r.rd_we = w; r.d = w ? d : '0; r.cwe = cw; r.c = cw ? c : 1'b0; r.err = e;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_wb(input wb_t e, input string tag);
    if (e.rd_we || e.cwe || e.err) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  // single-cycle access: drive, check strobes mid-cycle, release
  task automatic issue(input logic put, input logic [10:0] f, input logic [DW-1:0] rbv,
                       input logic [DW-1:0] rav, input logic [NP-1:0] e_rd,
                       input logic [NP-1:0] e_wr, input wb_t e, input string tag);
    @(negedge clk);
    op_valid = 1; opcode = 6'b010011; is_put = put; func = f; rb = rbv; ra = rav;
    expect_wb(e, tag);
    #1;
    chk({tag, " stall"}, 64'(stall), 64'd0);
    chk({tag, " read"}, 64'(s_read), 64'(e_rd));
    chk({tag, " write"}, 64'(m_write), 64'(e_wr));
    @(negedge clk);
    op_valid = 0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && (rd_we || carry_we || err_set)) begin
        wb_t got;
        got = mk(rd_we, rd_data, carry_we, carry, err_set);
        if (exp_q.size() == 0) begin
          chk("R1 unexpected write-back", 64'(got), 64'd0);
        end else begin
          wb_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " wb"}, {got.rd_we, got.cwe, got.c, got.err, 28'd0, got.d},
                          {e.rd_we, e.cwe, e.c, e.err, 28'd0, e.d});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rd_we", 64'(rd_we), 0);
    chk("R10 carry_we", 64'(carry_we), 0);
    chk("R10 err_set", 64'(err_set), 0);
    @(negedge clk) rst_n = 1;

    s_data[5*DW +: DW] = 32'hA5A5_0005;
    s_data[3*DW +: DW] = 32'h1234_0003;
    s_data[2*DW +: DW] = 32'hCAFE_0002;
    s_data[4*DW +: DW] = 32'h0BAD_0004;

    // R1: foreign opcode and reserved bit set
    s_exists = '1;
    @(negedge clk);
    op_valid = 1; opcode = 6'b010010; func = fn(1, 0, 0); rb = 5;
    #1;
    chk("R1 foreign read", 64'(s_read), 0);
    chk("R1 foreign stall", 64'(stall), 0);
    @(negedge clk);
    opcode = 6'b010011; func = fn(1, 0, 0) | 11'h001;
    #1;
    chk("R1 reserved read", 64'(s_read), 0);
    @(negedge clk) op_valid = 0; s_exists = '0;

    // R3 R5: polling get with data
    s_exists[5] = 1;
    issue(0, fn(1, 0, 0), 5, 0, 16'h0020, 0, mk(1, 32'hA5A5_0005, 1, 0, 0), "R3 R5 poll get");
    s_exists = '0;
    // R5: polling get, empty port
    issue(0, fn(1, 0, 0), 6, 0, 0, 0, mk(0, 0, 1, 1, 0), "R5 poll get empty");

    // R2 R3: blocking get stalls then completes
    @(negedge clk);
    op_valid = 1; opcode = 6'b010011; is_put = 0; func = fn(0, 0, 0); rb = 3;
    #1;
    chk("R2 get stall", 64'(stall), 1);
    chk("R2 get no read", 64'(s_read), 0);
    @(negedge clk);
    #1;
    chk("R2 get stall held", 64'(stall), 1);
    @(negedge clk);
    s_exists[3] = 1;
    expect_wb(mk(1, 32'h1234_0003, 0, 0, 0), "R3 block get");
    #1;
    chk("R2 get release", 64'(stall), 0);
    chk("R3 get read strobe", 64'(s_read), 64'h0008);
    @(negedge clk);
    op_valid = 0; s_exists = '0;

    // R7: control flag mismatches
    s_exists[2] = 1; s_ctrl[2] = 1;
    issue(0, fn(0, 0, 0), 2, 0, 16'h0004, 0, mk(1, 32'hCAFE_0002, 0, 0, 1), "R7 data get ctl1");
    s_ctrl[2] = 0;
    issue(0, fn(0, 1, 0), 2, 0, 16'h0004, 0, mk(1, 32'hCAFE_0002, 0, 0, 1), "R7 ctl get ctl0");
    s_ctrl[2] = 1;
    issue(0, fn(0, 1, 0), 2, 0, 16'h0004, 0, mk(1, 32'hCAFE_0002, 0, 0, 0), "R7 ctl get ctl1");
    s_exists = '0; s_ctrl = '0;

    // R2 R4: blocking data put stalls then completes
    m_full[9] = 1;
    @(negedge clk);
    op_valid = 1; opcode = 6'b010011; is_put = 1; func = fn(0, 0, 0); rb = 9; ra = 32'hDEAD_BEEF;
    #1;
    chk("R2 put stall", 64'(stall), 1);
    chk("R2 put no write", 64'(m_write), 0);
    @(negedge clk);
    m_full[9] = 0;
    #1;
    chk("R4 put release", 64'(stall), 0);
    chk("R4 put strobe", 64'(m_write), 64'h0200);
    chk("R4 put data", 64'(m_data[9*DW +: DW]), 64'hDEAD_BEEF);
    chk("R4 data put ctrl", 64'(m_ctrl[9]), 0);
    @(negedge clk);
    op_valid = 0;
    // R4: control put
    @(negedge clk);
    op_valid = 1; is_put = 1; func = fn(0, 1, 0); rb = 9; ra = 32'h0000_00C1;
    #1;
    chk("R4 ctl put strobe", 64'(m_write), 64'h0200);
    chk("R4 ctl put ctrl", 64'(m_ctrl[9]), 1);
    @(negedge clk);
    op_valid = 0;

    // R6: polling put full / not full
    m_full[1] = 1;
    issue(1, fn(1, 0, 0), 1, 32'h77, 0, 0, mk(0, 0, 1, 1, 0), "R6 poll put full");
    m_full[1] = 0;
    issue(1, fn(1, 0, 0), 1, 32'h77, 0, 16'h0002, mk(0, 0, 1, 0, 0), "R6 poll put ok");

    // R8: probe get with data, probe put
    s_exists[5] = 1; s_ctrl[5] = 1;
    issue(0, fn(1, 0, 1), 5, 0, 0, 0, mk(0, 0, 1, 0, 1), "R8 probe get");
    s_exists = '0; s_ctrl = '0;
    issue(1, fn(1, 0, 1), 7, 32'h55, 0, 0, mk(0, 0, 1, 0, 0), "R8 probe put");

    // R9: high index bits ignored
    s_exists[4] = 1;
    issue(0, fn(1, 0, 0), 32'hFFFF_FFF4, 0, 16'h0010, 0, mk(1, 32'h0BAD_0004, 1, 0, 0), "R9 masked index");
    s_exists = '0;

    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", 64'(exp_q.size()), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule